// File: doc/BRIEF.md
# Byte-Wide External SRAM Access Port

This block gives a processor access to an external SRAM with an 8-bit data bus through six memory-mapped registers. Software sets a base address, two offsets and a configuration, and then starts transfers as a side effect of register accesses. A write of the data-write register stores a word. A read is started in one of two ways, chosen by a configuration bit. In the first style, writing an offset register starts the read. In the second style, reading the data-read register starts the read; that read returns the previous result and fetches the next word.

Each word is 8, 16 or 24 bits wide and is carried as 1, 2 or 3 byte cycles on the external bus. The most significant byte goes first, and the byte address steps by one for each byte. A two-bit timing setting stretches every strobe. Software learns that a transfer has finished by polling a done flag or by taking an interrupt. A trigger that arrives while a transfer is running is dropped and recorded in a sticky overrun flag.

On a chip, the bidirectional data pin is split into a data-in port, a data-out port and an output-enable port. The pad ring joins these three into one pin.

Top module: `ext_sram_ctrl`

## Requirements
- R1: After reset, both strobes are high (inactive), the data output enable is low, `irq` is low, and every register reads as zero. Register select codes: 0 control/status, 1 data-write, 2 data-read, 3 base, 4 offset A, 5 offset B. Codes 6 and 7 read as zero.
- R2: A write to the data-write register starts a write at base + selected offset. Control bit 5 selects offset B when 1 and offset A when 0. Each byte cycle drives the next byte of the word, most significant first, at an address one higher than the byte before.
- R3: Control bits [1:0] give the word size. Code 0 is 1 byte, code 1 is 2 bytes, code 2 is 3 bytes, and code 3 also means 3 bytes. A word of N bytes uses its low 8·N bits.
- R4: Control bits [3:2] hold the timing setting t. Each strobe stays low for exactly t+1 clock cycles. There is exactly one cycle with both strobes high between the byte cycles of a word. The first strobe goes low in the cycle after the trigger edge.
- R5: When control bit 4 is 0, writing offset A or offset B loads that offset and starts a read at base + the written offset. When bit 4 is 1, an offset write only loads the offset. A base write never starts a transfer.
- R6: When control bit 4 is 1, a read of the data-read register returns the result of the last completed read. The same read also starts a new read at base + the selected offset.
- R7: A read assembles its bytes with the first byte as the most significant. The result is zero-extended to 24 bits and appears in the data-read register once the last byte cycle ends.
- R8: Status bit 7 (busy) reads 1 from the trigger edge until the edge that ends the last strobe.
- R9: A trigger that arrives while the block is busy causes no bus activity and sets the sticky overrun bit, status bit 9. Writing 1 to bit 9 of the control register clears it.
- R10: Status bit 8 (done) is set when a transfer completes. A new transfer start clears it, and so does writing 1 to control bit 8; other control writes leave it unchanged. `irq` equals done AND control bit 6.
- R11: Addresses are 22 bits wide. Base + offset, and the step from byte to byte, both wrap modulo 2^22.
- R12: The read strobe and the write strobe are never low at the same time. The data output enable is high exactly in the cycles where the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data-read register) |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data (combinational from reg_sel) |
| irq | output | 1 | Completion interrupt |
| sram_addr | output | 22 | External byte address |
| sram_dout | output | 8 | Data driven toward the SRAM |
| sram_din | input | 8 | Data returned by the SRAM |
| sram_dout_en | output | 1 | Output enable for the data pad |
| sram_rd_n | output | 1 | Active-low read strobe |
| sram_we_n | output | 1 | Active-low write strobe |

## Verification
The bench checks every bus cycle against a queue-based model, so it aims at the following corner cases:
- Strobe widths at timing settings 0 to 3, the gap cycle between bytes, and the first cycle after a trigger. An off-by-one in the strobe counter, or a missing gap, shifts the whole expected cycle stream.
- Address wraparound at the top of the 22-bit space. A design that carries into a 23rd bit drives a wrong address.
- A trigger issued during a long transfer. A design that accepts it restarts or corrupts the running transfer and misses the overrun flag.
- Size code 3, the return-old-then-fetch behaviour of the data-read trigger, and offset writes in the style where they must stay silent. A design that fires on those writes puts stray strobes on the bus.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

    localparam int SEL_W = 3;
    localparam int TIM_W = 2;
    localparam int SZ_W  = 2;

    // register select codes
    localparam logic [SEL_W-1:0] RS_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] RS_WDATA = 3'd1;
    localparam logic [SEL_W-1:0] RS_RDATA = 3'd2;
    localparam logic [SEL_W-1:0] RS_BASE  = 3'd3;
    localparam logic [SEL_W-1:0] RS_OFFA  = 3'd4;
    localparam logic [SEL_W-1:0] RS_OFFB  = 3'd5;

    // control / status bit positions
    localparam int CB_SIZE  = 0;
    localparam int CB_TIM   = 2;
    localparam int CB_STYLE = 4;
    localparam int CB_OSEL  = 5;
    localparam int CB_IE    = 6;
    localparam int CB_BUSY  = 7;
    localparam int CB_DONE  = 8;
    localparam int CB_OVR   = 9;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_STROBE = 2'd1,
        SQ_GAP    = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sram_byte_seq.sv
module sram_byte_seq
    import sram_port_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int BYTE_W = 8,
    parameter int WORD_W = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          start_rd_i,
    input  logic [ADDR_W-1:0]             start_addr_i,
    input  logic [WORD_W-1:0]             start_word_i,
    input  logic [((WORD_W/BYTE_W)>1 ? $clog2(WORD_W/BYTE_W) : 1)-1:0] start_len_i,
    input  logic [TIM_W-1:0]              start_tim_i,
    input  logic [BYTE_W-1:0]             sram_din_i,
    output logic                          busy_o,
    output logic                          fin_o,
    output logic                          fin_rd_o,
    output logic [WORD_W-1:0]             rd_word_o,
    output logic [ADDR_W-1:0]             sram_addr_o,
    output logic [BYTE_W-1:0]             sram_dout_o,
    output logic                          sram_oe_o,
    output logic                          sram_rd_n_o,
    output logic                          sram_we_n_o
);

    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int LEN_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int SH_W   = $clog2(WORD_W);

    typedef struct packed {
        seq_state_e          st;
        logic [TIM_W-1:0]    cnt;
        logic [TIM_W-1:0]    tim;
        logic [LEN_W-1:0]    left;
        logic                is_rd;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   wbuf;
        logic [WORD_W-1:0]   acc;
        logic [BYTE_W-1:0]   dout;
        logic                oe;
        logic                rd_n;
        logic                we_n;
    } seq_t;

    seq_t q, n;
    logic [SH_W-1:0]   shamt;
    logic [WORD_W-1:0] wstart;
    logic              fin;

    always_comb begin
        n      = q;
        fin    = 1'b0;
        shamt  = SH_W'(BYTE_W) * (SH_W'(NBYTES - 1) - SH_W'(start_len_i));
        wstart = start_word_i << shamt;
        unique case (q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    n.st    = SQ_STROBE;
                    n.cnt   = '0;
                    n.tim   = start_tim_i;
                    n.left  = start_len_i;
                    n.is_rd = start_rd_i;
                    n.addr  = start_addr_i;
                    n.wbuf  = wstart;
                    n.acc   = '0;
                    n.dout  = wstart[WORD_W-1 -: BYTE_W];
                    n.rd_n  = !start_rd_i;
                    n.we_n  = start_rd_i;
                    n.oe    = !start_rd_i;
                end
            end
            SQ_STROBE: begin
                if (q.cnt == q.tim) begin
                    if (q.is_rd) begin
                        n.acc = {q.acc[WORD_W-BYTE_W-1:0], sram_din_i};
                    end
                    n.wbuf = q.wbuf << BYTE_W;
                    n.rd_n = 1'b1;
                    n.we_n = 1'b1;
                    n.oe   = 1'b0;
                    if (q.left == '0) begin
                        n.st = SQ_IDLE;
                        fin  = 1'b1;
                    end else begin
                        n.st   = SQ_GAP;
                        n.left = q.left - 1'b1;
                    end
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            SQ_GAP: begin
                n.st   = SQ_STROBE;
                n.cnt  = '0;
                n.addr = q.addr + 1'b1;
                n.dout = q.wbuf[WORD_W-1 -: BYTE_W];
                n.rd_n = !q.is_rd;
                n.we_n = q.is_rd;
                n.oe   = !q.is_rd;
            end
            default: n.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.rd_n <= 1'b1;
            q.we_n <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign busy_o      = (q.st != SQ_IDLE);
    assign fin_o       = fin;
    assign fin_rd_o    = fin && q.is_rd;
    assign rd_word_o   = n.acc;
    assign sram_addr_o = q.addr;
    assign sram_dout_o = q.dout;
    assign sram_oe_o   = q.oe;
    assign sram_rd_n_o = q.rd_n;
    assign sram_we_n_o = q.we_n;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!q.rd_n && !q.we_n)); // R12
    AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe == !q.we_n); // R12
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_GAP) |=> (q.addr == $past(q.addr) + 1'b1)); // R2
    AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_STROBE) |-> (q.cnt <= q.tim)); // R4
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (q.st == SQ_IDLE)); // R9

endmodule

// File: rtl/sram_reg_file.sv
module sram_reg_file
    import sram_port_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int BYTE_W = 8,
    parameter int WORD_W = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SEL_W-1:0]              reg_sel_i,
    input  logic                          reg_wr_i,
    input  logic                          reg_rd_i,
    input  logic [WORD_W-1:0]             reg_wdata_i,
    output logic [WORD_W-1:0]             reg_rdata_o,
    output logic                          irq_o,
    input  logic                          busy_i,
    input  logic                          fin_i,
    input  logic                          fin_rd_i,
    input  logic [WORD_W-1:0]             rd_word_i,
    output logic                          start_o,
    output logic                          start_rd_o,
    output logic [ADDR_W-1:0]             start_addr_o,
    output logic [WORD_W-1:0]             start_word_o,
    output logic [((WORD_W/BYTE_W)>1 ? $clog2(WORD_W/BYTE_W) : 1)-1:0] start_len_o,
    output logic [TIM_W-1:0]              start_tim_o
);

    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int LEN_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef struct packed {
        logic [SZ_W-1:0]   size;
        logic [TIM_W-1:0]  tim;
        logic              style;
        logic              osel;
        logic              ie;
        logic              done;
        logic              ovr;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] offa;
        logic [ADDR_W-1:0] offb;
        logic [WORD_W-1:0] rdata;
    } regs_t;

    regs_t q, n;
    logic wr_trig, off_trig, rdr_trig, any_trig, start, ovr_set;
    logic [ADDR_W-1:0] off_pick;
    logic [LEN_W-1:0]  len_m1;

    always_comb begin
        wr_trig  = reg_wr_i && (reg_sel_i == RS_WDATA);
        off_trig = reg_wr_i && ((reg_sel_i == RS_OFFA) || (reg_sel_i == RS_OFFB)) && !q.style;
        rdr_trig = reg_rd_i && (reg_sel_i == RS_RDATA) && q.style;
        any_trig = wr_trig || off_trig || rdr_trig;
        start    = any_trig && !busy_i;
        ovr_set  = (any_trig && busy_i) || (wr_trig && rdr_trig);

        if (off_trig) off_pick = reg_wdata_i[ADDR_W-1:0];
        else          off_pick = q.osel ? q.offb : q.offa;

        if (int'(q.size) >= NBYTES - 1) len_m1 = LEN_W'(NBYTES - 1);
        else                            len_m1 = LEN_W'(q.size);

        n = q;
        if (reg_wr_i) begin
            unique case (reg_sel_i)
                RS_CTRL: begin
                    n.size  = reg_wdata_i[CB_SIZE +: SZ_W];
                    n.tim   = reg_wdata_i[CB_TIM +: TIM_W];
                    n.style = reg_wdata_i[CB_STYLE];
                    n.osel  = reg_wdata_i[CB_OSEL];
                    n.ie    = reg_wdata_i[CB_IE];
                    if (reg_wdata_i[CB_DONE]) n.done = 1'b0;
                    if (reg_wdata_i[CB_OVR])  n.ovr  = 1'b0;
                end
                RS_BASE: n.base = reg_wdata_i[ADDR_W-1:0];
                RS_OFFA: n.offa = reg_wdata_i[ADDR_W-1:0];
                RS_OFFB: n.offb = reg_wdata_i[ADDR_W-1:0];
                default: ;
            endcase
        end
        if (start)    n.done  = 1'b0;
        if (fin_i)    n.done  = 1'b1;
        if (fin_rd_i) n.rdata = rd_word_i;
        if (ovr_set)  n.ovr   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_sel_i)
            RS_CTRL: begin
                reg_rdata_o[CB_SIZE +: SZ_W]  = q.size;
                reg_rdata_o[CB_TIM +: TIM_W]  = q.tim;
                reg_rdata_o[CB_STYLE]         = q.style;
                reg_rdata_o[CB_OSEL]          = q.osel;
                reg_rdata_o[CB_IE]            = q.ie;
                reg_rdata_o[CB_BUSY]          = busy_i;
                reg_rdata_o[CB_DONE]          = q.done;
                reg_rdata_o[CB_OVR]           = q.ovr;
            end
            RS_RDATA: reg_rdata_o = q.rdata;
            RS_BASE:  reg_rdata_o[ADDR_W-1:0] = q.base;
            RS_OFFA:  reg_rdata_o[ADDR_W-1:0] = q.offa;
            RS_OFFB:  reg_rdata_o[ADDR_W-1:0] = q.offb;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign irq_o        = q.done && q.ie;
    assign start_o      = start;
    assign start_rd_o   = !wr_trig;
    assign start_addr_o = q.base + off_pick;
    assign start_word_o = reg_wdata_i;
    assign start_len_o  = len_m1;
    assign start_tim_o  = q.tim;

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && any_trig) |=> q.ovr); // R9
    AST_DONE_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i |=> q.done); // R10
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |-> !q.done); // R10

endmodule

// File: rtl/ext_sram_ctrl.sv
module ext_sram_ctrl
    import sram_port_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int BYTE_W = 8,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [BYTE_W-1:0] sram_dout,
    input  logic [BYTE_W-1:0] sram_din,
    output logic              sram_dout_en,
    output logic              sram_rd_n,
    output logic              sram_we_n
);

    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int LEN_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic              busy, fin, fin_rd, start, start_rd;
    logic [WORD_W-1:0] rd_word, start_word;
    logic [ADDR_W-1:0] start_addr;
    logic [LEN_W-1:0]  start_len;
    logic [TIM_W-1:0]  start_tim;

    sram_reg_file #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_sel_i    (reg_sel),
        .reg_wr_i     (reg_wr),
        .reg_rd_i     (reg_rd),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .irq_o        (irq),
        .busy_i       (busy),
        .fin_i        (fin),
        .fin_rd_i     (fin_rd),
        .rd_word_i    (rd_word),
        .start_o      (start),
        .start_rd_o   (start_rd),
        .start_addr_o (start_addr),
        .start_word_o (start_word),
        .start_len_o  (start_len),
        .start_tim_o  (start_tim)
    );

    sram_byte_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .start_rd_i   (start_rd),
        .start_addr_i (start_addr),
        .start_word_i (start_word),
        .start_len_i  (start_len),
        .start_tim_i  (start_tim),
        .sram_din_i   (sram_din),
        .busy_o       (busy),
        .fin_o        (fin),
        .fin_rd_o     (fin_rd),
        .rd_word_o    (rd_word),
        .sram_addr_o  (sram_addr),
        .sram_dout_o  (sram_dout),
        .sram_oe_o    (sram_dout_en),
        .sram_rd_n_o  (sram_rd_n),
        .sram_we_n_o  (sram_we_n)
    );

    AST_IRQ_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy); // R10

endmodule

// File: tb/ext_sram_ctrl_tb.sv
`timescale 1ns/1ps
module ext_sram_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        irq;
    logic [21:0] sram_addr;
    logic [7:0]  sram_dout;
    logic [7:0]  sram_din;
    logic        sram_dout_en, sram_rd_n, sram_we_n;

    always #2.5 clk = ~clk;

    ext_sram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sram_addr(sram_addr),
        .sram_dout(sram_dout), .sram_din(sram_din), .sram_dout_en(sram_dout_en),
        .sram_rd_n(sram_rd_n), .sram_we_n(sram_we_n)
    );

    function automatic logic [7:0] pat(input logic [21:0] a);
        return a[7:0] ^ {a[13:8], a[21:20]} ^ 8'hA5;
    endfunction

    assign sram_din = !sram_rd_n ? pat(sram_addr) : 8'h00;

    int checks = 0;
    int errors = 0;
    // model entry: [31] read strobe, [30] write strobe, [29:8] address, [7:0] data
    logic [31:0] expq[$];
    bit          cur_active = 0;
    int          sz = 0, tm = 0;
    bit          sty = 0, osel = 0, ie = 0;
    logic [21:0] base = '0, offa = '0, offb = '0;
    logic [23:0] rdata_sh = '0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int nbytes(input int code);
        return (code == 0) ? 1 : ((code == 1) ? 2 : 3);
    endfunction

    function automatic bit mbusy();
        return (expq.size() != 0) || cur_active;
    endfunction

    function automatic logic [23:0] stat(input bit ovr, input bit dn, input bit bsy);
        return {14'b0, ovr, dn, bsy, ie, osel, sty, 2'(tm), 2'(sz)};
    endfunction

    function automatic logic [23:0] ctrlw();
        return {17'b0, ie, osel, sty, 2'(tm), 2'(sz)};
    endfunction

    task automatic trigger(input bit is_rd, input logic [21:0] a, input logic [23:0] w);
        int nb;
        logic [23:0] acc;
        if (mbusy()) return;
        nb  = nbytes(sz);
        acc = '0;
        for (int k = 0; k < nb; k++) begin
            logic [21:0] ak;
            logic [7:0]  bv;
            ak = a + 22'(k);
            bv = 8'(w >> (8 * (nb - 1 - k)));
            acc = (acc << 8) | 24'(pat(ak));
            for (int c = 0; c <= tm; c++) expq.push_back({is_rd, !is_rd, ak, bv});
            if (k < nb - 1) expq.push_back(32'h0);
        end
        if (is_rd) rdata_sh = acc;
    endtask

    task automatic wr(input logic [2:0] s, input logic [23:0] d);
        case (s)
            3'd0: begin sz = int'(d[1:0]); tm = int'(d[3:2]); sty = d[4]; osel = d[5]; ie = d[6]; end
            3'd1: trigger(1'b0, base + (osel ? offb : offa), d);
            3'd3: base = d[21:0];
            3'd4: begin offa = d[21:0]; if (!sty) trigger(1'b1, base + offa, '0); end
            3'd5: begin offb = d[21:0]; if (!sty) trigger(1'b1, base + offb, '0); end
            default: ;
        endcase
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [23:0] d);
        if (s == 3'd2 && sty) trigger(1'b1, base + (osel ? offb : offa), '0);
        reg_sel = s; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        while (mbusy()) @(negedge clk);
    endtask

    // cycle-by-cycle bus comparison
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                logic [31:0] e;
                e = (expq.size() != 0) ? expq.pop_front() : 32'h0;
                cur_active = e[31] | e[30];
                check((sram_rd_n == !e[31]) && (sram_we_n == !e[30]), "R4 strobes",
                      {30'b0, sram_rd_n, sram_we_n}, {30'b0, !e[31], !e[30]});
                check(sram_dout_en == e[30], "R12 drive", {31'b0, sram_dout_en}, {31'b0, e[30]});
                if (cur_active) check(sram_addr == e[29:8], "R2 addr", {10'b0, sram_addr}, {10'b0, e[29:8]});
                if (e[30]) check(sram_dout == e[7:0], "R2 data", {24'b0, sram_dout}, {24'b0, e[7:0]});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] v, old;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sram_rd_n && sram_we_n && !sram_dout_en && !irq, "R1 pins",
              {28'b0, sram_rd_n, sram_we_n, sram_dout_en, irq}, 32'hC);
        rd(3'd0, v); check(v == 24'h0, "R1 ctrl", v, 0);
        rd(3'd2, v); check(v == 24'h0, "R1 rdata", v, 0);
        rd(3'd7, v); check(v == 24'h0, "R1 unused", v, 0);

        // R5: offset writes silent in data-read trigger style
        wr(3'd0, 24'h52);
        wr(3'd3, 24'h001000);
        wr(3'd4, 24'h000010);
        wr(3'd5, 24'h000200);
        rd(3'd0, v); check(v == stat(0, 0, 0), "R5 no start", v, stat(0, 0, 0));
        rd(3'd4, v); check(v == 24'h10, "R5 offset load", v, 24'h10);

        // R2 R3 R8 R10: 24-bit write, timing 0
        wr(3'd1, 24'hABCDEF);
        rd(3'd0, v); check(v == stat(0, 0, 1), "R8 busy", v, stat(0, 0, 1));
        wait_idle();
        rd(3'd0, v); check(v == stat(0, 1, 0), "R10 done", v, stat(0, 1, 0));
        check(irq == 1'b1, "R10 irq set", {31'b0, irq}, 1);
        wr(3'd0, ctrlw() | 24'h100);
        check(irq == 1'b0, "R10 irq clear", {31'b0, irq}, 0);

        // R4 R9: 16-bit write, timing 3, overrun
        wr(3'd0, 24'h5D);
        wr(3'd1, 24'h123456);
        wr(3'd1, 24'h999999);
        rd(3'd0, v); check(v == stat(1, 0, 1), "R9 overrun", v, stat(1, 0, 1));
        wait_idle();
        wr(3'd0, ctrlw() | 24'h200);
        rd(3'd0, v); check(v == stat(0, 1, 0), "R9 clear", v, stat(0, 1, 0));

        // R5 R7 R10: offset-write read style
        wr(3'd0, 24'h0D);
        rd(3'd0, v); check(v == stat(0, 1, 0), "R10 ctrl keeps done", v, stat(0, 1, 0));
        wr(3'd5, 24'h000300);
        rd(3'd0, v); check(v == stat(0, 0, 1), "R10 start clears done", v, stat(0, 0, 1));
        wait_idle();
        check(irq == 1'b0, "R10 irq masked", {31'b0, irq}, 0);
        rd(3'd2, v); check(v == rdata_sh, "R7 read word", v, rdata_sh);

        // R11: wraparound read
        wr(3'd3, 24'h3FFFFE);
        wr(3'd0, 24'h06);
        wr(3'd4, 24'h000000);
        wait_idle();
        rd(3'd2, v); check(v == rdata_sh, "R11 wrap read", v, rdata_sh);

        // R3 R11: single byte write through offset B with wrap
        wr(3'd0, 24'h34);
        wr(3'd1, 24'h000077);
        wait_idle();

        // R6: data-read trigger returns old, fetches new
        wr(3'd0, 24'h1A);
        wr(3'd4, 24'h000055);
        old = rdata_sh;
        rd(3'd2, v); check(v == old, "R6 returns previous", v, old);
        wait_idle();
        old = rdata_sh;
        rd(3'd2, v); check(v == old, "R6 new result", v, old);
        wait_idle();

        // R3: size code 3 behaves as 24-bit
        wr(3'd0, 24'h13);
        wr(3'd1, 24'hC0FFEE);
        wait_idle();
        rd(3'd0, v); check(v == stat(0, 1, 0), "R3 size3 done", v, stat(0, 1, 0));
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule